// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Transmit and Receive Queues

This block is a small asynchronous serial port that sits on a 32-bit register bus and exposes two word registers. Word 0 is the data port. A write to it queues one character for transmission. A read from it either takes the oldest received character or returns an empty marker. Word 1 holds the bit-timing divider. Software may write characters one after another without checking a ready flag, because a transmit queue absorbs them while the line is busy.

Frames use one start bit, eight data bits and one stop bit. A receiver double-registers the incoming line, looks for a falling start edge and then samples each bit near its centre. Both directions take their bit length from the same divider.

Top module: `uart_regport`

## Requirements
- R1: After reset `tx_o` is high, the divider reads back as 0, and a read of word 0 returns 0x80000000.
- R2: A write to word 1 (`bus_addr`=1) stores `bus_wdata[DIV_W-1:0]`. A read of word 1 returns that value zero-extended to 32 bits.
- R3: A write to word 0 sends `bus_wdata[7:0]` as one frame: a low start bit, then data bits 0 to 7 in that order, then a high stop bit. The line is high whenever no frame is in progress.
- R4: Each transmitted bit lasts exactly divider + 2 clock cycles, so a divider of 0 gives 2-cycle bits.
- R5: Characters written while the transmitter is busy are queued and sent later, in the order written, with none lost while the queue has room.
- R6: With writes to word 0 on every cycle from idle, the first TXQ_DEPTH+1 characters are sent (one in the shifter, TXQ_DEPTH queued) and the later writes are dropped.
- R7: A valid received frame is returned by a read of word 0 as `{24'b0, byte}` with bit 31 clear, and that read removes the byte from the receive queue.
- R8: A read of word 0 with nothing received returns 0x80000000 and changes no state. Characters that arrive afterwards are still returned in arrival order.
- R9: A received frame whose stop bit samples low is discarded.
- R10: A low pulse on `rx_i` that has ended before the middle of the start bit does not produce a character.
- R11: When RXQ_DEPTH characters are waiting, further received frames are dropped, and the stored ones are read back in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Word select: 0 data, 1 divider |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe; a word-0 read removes a byte at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| rx_i | input | 1 | Serial input, idle high |
| tx_o | output | 1 | Serial output, idle high |

## Verification
On the transmit side the bench uses short directed bursts of edge values such as 0x00, 0xFF and alternating bits, which expose bit-order and framing faults. Random bytes sent at random dividers from 0 upward expose period errors that only show at some divider values. A cycle-by-cycle burst longer than the queue separates correct dropping from both overwriting and off-by-one capacity. Start-bit length measured at the smallest and at a large divider pins the exact period. On the receive side, clean frames, a frame with a low stop bit, a short start glitch, a queue overflow and random bytes at random dividers tell apart correct centre sampling, framing rejection, false-start filtering and drop-on-full.

// File: rtl/uart_regport.sv
module uart_regport #(
  parameter int DIV_W     = 16,
  parameter int TXQ_DEPTH = 16,
  parameter int RXQ_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_i,
  output logic        tx_o
);
  localparam int TQ_AW = (TXQ_DEPTH > 1) ? $clog2(TXQ_DEPTH) : 1;
  localparam int RQ_AW = (RXQ_DEPTH > 1) ? $clog2(RXQ_DEPTH) : 1;
  localparam int TQ_CW = $clog2(TXQ_DEPTH + 1);
  localparam int RQ_CW = $clog2(RXQ_DEPTH + 1);
  localparam logic [TQ_CW-1:0] TQ_FULL = TQ_CW'(TXQ_DEPTH);
  localparam logic [RQ_CW-1:0] RQ_FULL = RQ_CW'(RXQ_DEPTH);
  localparam logic [TQ_AW-1:0] TQ_LAST = TQ_AW'(TXQ_DEPTH - 1);
  localparam logic [RQ_AW-1:0] RQ_LAST = RQ_AW'(RXQ_DEPTH - 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   bit_len, half;
  assign bit_len = {1'b0, div_q} + 1'b1;
  assign half    = bit_len >> 1;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else if (bus_wr && bus_addr) div_q <= bus_wdata[DIV_W-1:0];

  // transmit queue
  logic [7:0]       tq_mem [TXQ_DEPTH];
  logic [TQ_AW-1:0] tq_wp, tq_rp;
  logic [TQ_CW-1:0] tq_cnt;
  logic             tx_busy, tq_push, tq_pop;
  assign tq_push = bus_wr && !bus_addr && (tq_cnt != TQ_FULL);
  assign tq_pop  = !tx_busy && (tq_cnt != '0);

  always_ff @(posedge clk)
    if (tq_push) tq_mem[tq_wp] <= bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tq_wp <= '0; tq_rp <= '0; tq_cnt <= '0;
    end else begin
      if (tq_push) tq_wp <= (tq_wp == TQ_LAST) ? '0 : tq_wp + 1'b1;
      if (tq_pop)  tq_rp <= (tq_rp == TQ_LAST) ? '0 : tq_rp + 1'b1;
      case ({tq_push, tq_pop})
        2'b10:   tq_cnt <= tq_cnt + 1'b1;
        2'b01:   tq_cnt <= tq_cnt - 1'b1;
        default: tq_cnt <= tq_cnt;
      endcase
    end

  // transmitter
  logic [9:0]     tsh;
  logic [3:0]     tbits;
  logic [DIV_W:0] tcnt;
  assign tx_o = tsh[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tsh <= '1; tbits <= '0; tcnt <= '0;
    end else if (tq_pop) begin
      tx_busy <= 1'b1; tsh <= {1'b1, tq_mem[tq_rp], 1'b0}; tbits <= '0; tcnt <= '0;
    end else if (tx_busy) begin
      if (tcnt == bit_len) begin
        tcnt <= '0;
        tsh  <= {1'b1, tsh[9:1]};
        if (tbits == 4'd9) tx_busy <= 1'b0;
        else               tbits   <= tbits + 1'b1;
      end else tcnt <= tcnt + 1'b1;
    end

  // receiver
  logic [1:0]     rsync;
  logic           rs, rprev, r_busy;
  logic [3:0]     rbits;
  logic [DIV_W:0] rcnt;
  logic [7:0]     rsh;
  logic           rq_push, rq_pop;
  logic [7:0]       rq_mem [RXQ_DEPTH];
  logic [RQ_AW-1:0] rq_wp, rq_rp;
  logic [RQ_CW-1:0] rq_cnt;
  assign rs      = rsync[1];
  assign rq_push = r_busy && (rcnt == '0) && (rbits == 4'd9) && rs && (rq_cnt != RQ_FULL);
  assign rq_pop  = bus_rd && !bus_addr && (rq_cnt != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsync <= '1; rprev <= 1'b1; r_busy <= 1'b0; rbits <= '0; rcnt <= '0; rsh <= '0;
    end else begin
      rsync <= {rsync[0], rx_i};
      rprev <= rs;
      if (!r_busy) begin
        if (rprev && !rs) begin
          r_busy <= 1'b1; rbits <= '0;
          rcnt   <= (half != '0) ? half - 1'b1 : '0;
        end
      end else if (rcnt != '0) begin
        rcnt <= rcnt - 1'b1;
      end else begin
        rcnt <= bit_len;
        if (rbits == 4'd0) begin
          if (rs) r_busy <= 1'b0;
          else    rbits  <= 4'd1;
        end else if (rbits != 4'd9) begin
          rsh   <= {rs, rsh[7:1]};
          rbits <= rbits + 1'b1;
        end else r_busy <= 1'b0;
      end
    end

  always_ff @(posedge clk)
    if (rq_push) rq_mem[rq_wp] <= rsh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rq_wp <= '0; rq_rp <= '0; rq_cnt <= '0;
    end else begin
      if (rq_push) rq_wp <= (rq_wp == RQ_LAST) ? '0 : rq_wp + 1'b1;
      if (rq_pop)  rq_rp <= (rq_rp == RQ_LAST) ? '0 : rq_rp + 1'b1;
      case ({rq_push, rq_pop})
        2'b10:   rq_cnt <= rq_cnt + 1'b1;
        2'b01:   rq_cnt <= rq_cnt - 1'b1;
        default: rq_cnt <= rq_cnt;
      endcase
    end

  assign bus_rdata = bus_addr        ? 32'(div_q) :
                     (rq_cnt == '0)  ? 32'h8000_0000 :
                                       {24'b0, rq_mem[rq_rp]};
endmodule

// File: rtl/uart_regport_chk.sv
module uart_regport_chk #(
  parameter int DIV_W = 16,
  parameter int TXQ_DEPTH = 16,
  parameter int RXQ_DEPTH = 16,
  parameter int TQ_CW = 5,
  parameter int RQ_CW = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             tx_o,
  input logic             tx_busy,
  input logic [TQ_CW-1:0] tq_cnt,
  input logic [RQ_CW-1:0] rq_cnt,
  input logic [DIV_W-1:0] div_q
);
  assert_txq_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tq_cnt) <= TXQ_DEPTH);
  assert_rxq_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rq_cnt) <= RXQ_DEPTH);
  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr && rq_cnt == '0) |-> bus_rdata == 32'h8000_0000);
  assert_idle_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_o);
  assert_div_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr) |=> div_q == $past(bus_wdata[DIV_W-1:0]));
  assert_queue_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && int'(tq_cnt) < TXQ_DEPTH && tx_busy) |=> tq_cnt == $past(tq_cnt) + 1'b1);
endmodule

bind uart_regport uart_regport_chk #(
  .DIV_W(DIV_W), .TXQ_DEPTH(TXQ_DEPTH), .RXQ_DEPTH(RXQ_DEPTH),
  .TQ_CW(TQ_CW), .RQ_CW(RQ_CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_o(tx_o), .tx_busy(tx_busy),
  .tq_cnt(tq_cnt), .rq_cnt(rq_cnt), .div_q(div_q)
);

// File: tb/sim_uart_regport.sv
module sim_uart_regport;
  localparam int CLK_PERIOD = 10;
  localparam int TXQ = 16;
  localparam int RXQ = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rx_i = 1'b1, tx_o;

  int checks = 0, fails = 0, cur_p = 2, stop_bad = 0;
  logic [7:0] got[$];
  logic [7:0] exp_q[$];

  uart_regport #(.DIV_W(16), .TXQ_DEPTH(TXQ), .RXQ_DEPTH(RXQ)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_i(rx_i), .tx_o(tx_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic int period(int div);
    return div + 2;
  endfunction

  task automatic bus_write(logic a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_div(int div);
    bus_write(1'b1, 32'(div));
    cur_p = period(div);
  endtask

  task automatic send_frame(logic [7:0] b, logic stop, int p);
    rx_i = 1'b0; repeat (p) @(negedge clk);
    for (int j = 0; j < 8; j++) begin rx_i = b[j]; repeat (p) @(negedge clk); end
    rx_i = stop; repeat (p) @(negedge clk);
    rx_i = 1'b1; repeat (p) @(negedge clk);
  endtask

  task automatic wait_tx(int n);
    repeat (n * (10 * cur_p + 2) + 4 * cur_p + 10) @(negedge clk);
  endtask

  task automatic compare_tx(string req);
    check({req, " frame count"}, 32'(got.size()), 32'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      check({req, " byte"}, 32'(got[i]), 32'(exp_q[i]));
    check({req, " stop bits"}, 32'(stop_bad), 32'd0);
    got.delete(); exp_q.delete(); stop_bad = 0;
  endtask

  // serial line monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && tx_o === 1'b0) begin
      logic [7:0] b;
      repeat ((cur_p - 1) / 2) @(negedge clk);
      for (int j = 0; j < 8; j++) begin repeat (cur_p) @(negedge clk); b[j] = tx_o; end
      repeat (cur_p) @(negedge clk);
      if (tx_o !== 1'b1) stop_bad++;
      got.push_back(b);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic measure_start(int div, string req);
    int n;
    set_div(div);
    bus_write(1'b0, 32'h0000_0001);
    n = 0;
    while (tx_o !== 1'b0) @(negedge clk);
    while (tx_o === 1'b0) begin n++; @(negedge clk); end
    check(req, 32'(n), 32'(period(div)));
    exp_q.push_back(8'h01);
    wait_tx(1);
    compare_tx(req);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 tx idle", 32'(tx_o), 32'd1);
    bus_read(1'b1, d); check("R1 divider", d, 32'd0);
    bus_read(1'b0, d); check("R1 data empty", d, 32'h8000_0000);

    // R2 divider register
    bus_write(1'b1, 32'h0000_1234); bus_read(1'b1, d); check("R2 readback", d, 32'h1234);
    bus_write(1'b1, 32'hFFFF_FFFF); bus_read(1'b1, d); check("R2 width", d, 32'h0000_FFFF);

    // R4 bit period
    measure_start(0, "R4 div0");
    measure_start(22, "R4 div22");

    // R3 R5 directed burst
    set_div(4);
    begin
      logic [7:0] v[4] = '{8'hA5, 8'h3C, 8'h00, 8'hFF};
      for (int i = 0; i < 4; i++) begin bus_write(1'b0, {24'hABCDEF, v[i]}); exp_q.push_back(v[i]); end
    end
    wait_tx(4);
    compare_tx("R3 R5 directed");

    // R6 overflow: write every cycle
    set_div(2);
    bus_addr = 1'b0; bus_wr = 1'b1;
    for (int i = 0; i < TXQ + 4; i++) begin
      bus_wdata = 32'(8'h40 + i);
      if (i <= TXQ) exp_q.push_back(8'(8'h40 + i));
      @(negedge clk);
    end
    bus_wr = 1'b0;
    wait_tx(TXQ + 1);
    compare_tx("R6 overflow");

    // R3 R4 R5 random batches
    for (int k = 0; k < 6; k++) begin
      int n = 1 + int'($urandom_range(7));
      set_div(int'($urandom_range(12)));
      for (int i = 0; i < n; i++) begin
        logic [7:0] b = 8'($urandom);
        bus_write(1'b0, {24'h0, b}); exp_q.push_back(b);
      end
      wait_tx(n);
      compare_tx("R5 random");
    end

    // R7 R8 receive
    set_div(6);
    send_frame(8'h5A, 1'b1, cur_p);
    bus_read(1'b0, d); check("R7 rx byte", d, 32'h0000_005A);
    bus_read(1'b0, d); check("R8 empty after pop", d, 32'h8000_0000);
    bus_read(1'b0, d); check("R8 empty twice", d, 32'h8000_0000);
    send_frame(8'hC3, 1'b1, cur_p);
    send_frame(8'h81, 1'b1, cur_p);
    bus_read(1'b0, d); check("R8 order first", d, 32'h0000_00C3);
    bus_read(1'b0, d); check("R8 order second", d, 32'h0000_0081);

    // R9 bad stop
    send_frame(8'h77, 1'b0, cur_p);
    send_frame(8'h11, 1'b1, cur_p);
    bus_read(1'b0, d); check("R9 good after bad", d, 32'h0000_0011);
    bus_read(1'b0, d); check("R9 bad dropped", d, 32'h8000_0000);

    // R10 glitch
    set_div(10);
    rx_i = 1'b0; repeat (2) @(negedge clk); rx_i = 1'b1;
    repeat (4 * cur_p) @(negedge clk);
    bus_read(1'b0, d); check("R10 glitch ignored", d, 32'h8000_0000);
    send_frame(8'h42, 1'b1, cur_p);
    bus_read(1'b0, d); check("R10 frame after glitch", d, 32'h0000_0042);

    // R11 receive overflow
    set_div(4);
    for (int i = 0; i < RXQ + 2; i++) send_frame(8'(i + 1), 1'b1, cur_p);
    for (int i = 0; i < RXQ; i++) begin
      bus_read(1'b0, d); check("R11 stored", d, 32'(i + 1));
    end
    bus_read(1'b0, d); check("R11 extra dropped", d, 32'h8000_0000);

    // R7 random receive
    for (int k = 0; k < 12; k++) begin
      logic [7:0] b = 8'($urandom);
      set_div(4 + int'($urandom_range(8)));
      send_frame(b, 1'b1, cur_p);
      bus_read(1'b0, d); check("R7 random rx", d, {24'h0, b});
    end

    summary();
  end
endmodule